// File: doc/BRIEF.md
# Narrow-Memory Read Packing Bus Adapter

This adapter connects a 32-bit word request port to an external asynchronous memory (SRAM or ROM) whose data bus is 8, 16 or 32 bits wide. The width is taken from a configuration input while reset is held and is kept until the next reset. A processor can therefore boot straight from a narrow ROM: each word read becomes a short series of byte or half-word external reads, and the adapter packs the results into one 32-bit word before it answers.

Word writes are split into narrow external writes in the same way. An endianness input chooses whether the lowest-addressed byte (or half-word) sits in the low or the high lanes of the word. A ROM read uses exactly the same cycle as an SRAM read. Each external beat holds its strobe for a fixed number of cycles set by a parameter. A one-cycle idle gap separates consecutive beats, and chip enable stays low across the whole access.

Top module: `nm_adapter`

## Requirements
- R1: The port width is sampled from `cfg_width` on every clock edge while `rst_n` is low. The encodings are 2'b00 = 8 bits, 2'b01 = 16 bits, and 2'b10 or 2'b11 = 32 bits. Changes on `cfg_width` after reset have no effect on the number of beats.
- R2: With an 8-bit port, a request at word address A makes 4 external beats at byte addresses 4A+0, 4A+1, 4A+2 and 4A+3, in that order. Each read beat takes data from `ext_din[7:0]`.
- R3: With a 16-bit port, a request makes 2 beats at half-word addresses 2A+0 and then 2A+1. Each read beat takes data from `ext_din[15:0]`.
- R4: With a 32-bit port, a request makes one beat at address A. The word goes to or from the full 32-bit bus.
- R5: With `big_endian`=0, the byte at offset k goes to bits 8k+7:8k, and the half-word at offset h goes to bits 16h+15:16h. With `big_endian`=1, byte k goes to bits 8(3-k)+7:8(3-k), and half-word h goes to bits 16(1-h)+15:16(1-h). The endianness value is taken when a request is accepted.
- R6: Writes are always full words. On a narrow port, each write beat drives the lane selected by R5 on `ext_dout[7:0]` (8-bit port) or `ext_dout[15:0]` (16-bit port).
- R7: Each beat holds `ext_oe_n` (read) or `ext_we_n` (write) low for exactly HOLD cycles, with `ext_addr` stable. Consecutive beats are separated by one cycle with the strobe high. `ext_ce_n` is low from the first beat cycle through the last beat cycle.
- R8: `ack` pulses for one cycle, N*(HOLD+1) cycles after the accepting edge, where N is the beat count. On a read, `rdata` holds the packed word during that cycle.
- R9: A request is accepted only when `busy` is low. `busy` is high from the cycle after acceptance through the `ack` cycle. A request presented while `busy` is high, including in the `ack` cycle, is ignored.
- R10: `ext_oe_n` and `ext_we_n` are never low together, and neither is low unless `ext_ce_n` is low. During and right after reset, all three are high and `busy` and `ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_width | input | 2 | Port width code, sampled during reset |
| big_endian | input | 1 | 0: lowest address in low lanes; 1: in high lanes |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = word write, 0 = word read |
| req_addr | input | AW | Word address |
| req_wdata | input | 32 | Write word |
| busy | output | 1 | Transaction in progress |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Packed read word |
| ext_ce_n | output | 1 | External chip enable, active low |
| ext_oe_n | output | 1 | External output enable, active low |
| ext_we_n | output | 1 | External write enable, active low |
| ext_addr | output | AW+2 | External address in port-width units |
| ext_dout | output | 32 | External write data (narrow data in low lanes) |
| ext_din | input | 32 | External read data (narrow data in low lanes) |

## Verification
Two events can meet in the same cycle: the acknowledge of one transaction and a new request on the request port. The bench holds a write request from early in a read until after the acknowledge cycle. It then checks that only the read's beats appeared, that no write strobe occurred, and that `busy` falls right after the acknowledge. A second scenario presents a request in the first idle cycle after an acknowledge. It is judged accepted by its beat addresses, its returned word and its exact latency.

// File: rtl/nm_pkg.sv
package nm_pkg;

  localparam int DW = 32;

  typedef enum logic [1:0] {
    PW8  = 2'd0,
    PW16 = 2'd1,
    PW32 = 2'd2
  } port_w_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STROBE = 2'd1,
    ST_GAP    = 2'd2,
    ST_ACK    = 2'd3
  } seq_st_e;

  function automatic port_w_e decode_width(input logic [1:0] code);
    if (code[1])      return PW32;
    else if (code[0]) return PW16;
    else              return PW8;
  endfunction

  function automatic logic [2:0] beats_of(input port_w_e w);
    case (w)
      PW8:     return 3'd4;
      PW16:    return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

  // lane (byte lane for 8-bit, half lane for 16-bit) of beat idx
  function automatic logic [1:0] lane_sel(input port_w_e w, input logic [1:0] idx,
                                          input logic be);
    case (w)
      PW8:     return be ? (2'd3 - idx) : idx;
      PW16:    return {1'b0, be ? ~idx[0] : idx[0]};
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/nm_width_latch.sv
module nm_width_latch
  import nm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_width,
  output port_w_e    width
);

  port_w_e width_q;

  always_ff @(posedge clk) begin
    if (!rst_n) width_q <= decode_width(cfg_width);
  end

  assign width = width_q;

endmodule

// File: rtl/nm_beat_seq.sv
module nm_beat_seq
  import nm_pkg::*;
#(
  parameter int HOLD = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] nbeats,
  output logic       accept,
  output logic       busy,
  output logic       active,
  output logic       strobe,
  output logic       beat_end,
  output logic       last_beat,
  output logic       ack,
  output logic [1:0] beat_idx
);

  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HOLD - 1);

  seq_st_e       st_q;
  logic [CW-1:0] cnt_q;
  logic [1:0]    idx_q;

  assign accept    = (st_q == ST_IDLE) && req_valid;
  assign busy      = (st_q != ST_IDLE);
  assign strobe    = (st_q == ST_STROBE);
  assign active    = (st_q == ST_STROBE) || (st_q == ST_GAP);
  assign beat_end  = strobe && (cnt_q == CNT_LAST);
  assign last_beat = ({1'b0, idx_q} == (nbeats - 3'd1));
  assign ack       = (st_q == ST_ACK);
  assign beat_idx  = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            st_q  <= ST_STROBE;
            cnt_q <= '0;
            idx_q <= '0;
          end
        end
        ST_STROBE: begin
          if (beat_end) begin
            cnt_q <= '0;
            if (last_beat) begin
              st_q <= ST_ACK;
            end else begin
              st_q  <= ST_GAP;
              idx_q <= idx_q + 2'd1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_GAP:  st_q <= ST_STROBE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nm_lane_path.sv
module nm_lane_path
  import nm_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          req_write,
  input  logic          big_endian,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  port_w_e       width,
  input  logic [1:0]    beat_idx,
  input  logic          beat_end,
  input  logic [DW-1:0] ext_din,
  output logic          wr_q,
  output logic [AW+1:0] ext_addr,
  output logic [DW-1:0] ext_dout,
  output logic [DW-1:0] rdata
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdat_q;
  logic [DW-1:0] rd_q;
  logic          be_q;
  logic [1:0]    lane;
  logic          capture;

  assign lane    = lane_sel(width, beat_idx, be_q);
  assign capture = beat_end && !wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
      wr_q   <= 1'b0;
      be_q   <= 1'b0;
    end else if (accept) begin
      addr_q <= req_addr;
      wdat_q <= req_wdata;
      wr_q   <= req_write;
      be_q   <= big_endian;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (capture) begin
      case (width)
        PW8:     rd_q[{lane, 3'b000} +: 8]        <= ext_din[7:0];
        PW16:    rd_q[{lane[0], 4'b0000} +: 16]   <= ext_din[15:0];
        default: rd_q                              <= ext_din;
      endcase
    end
  end

  always_comb begin
    case (width)
      PW8:     ext_addr = {addr_q, beat_idx};
      PW16:    ext_addr = {1'b0, addr_q, beat_idx[0]};
      default: ext_addr = {2'b00, addr_q};
    endcase
  end

  always_comb begin
    ext_dout = '0;
    if (wr_q) begin
      case (width)
        PW8:     ext_dout[7:0]  = wdat_q[{lane, 3'b000} +: 8];
        PW16:    ext_dout[15:0] = wdat_q[{lane[0], 4'b0000} +: 16];
        default: ext_dout       = wdat_q;
      endcase
    end
  end

  assign rdata = rd_q;

endmodule

// File: rtl/nm_adapter.sv
module nm_adapter
  import nm_pkg::*;
#(
  parameter int AW   = 16,
  parameter int HOLD = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_width,
  input  logic          big_endian,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          busy,
  output logic          ack,
  output logic [31:0]   rdata,
  output logic          ext_ce_n,
  output logic          ext_oe_n,
  output logic          ext_we_n,
  output logic [AW+1:0] ext_addr,
  output logic [31:0]   ext_dout,
  input  logic [31:0]   ext_din
);

  port_w_e    width_q;
  logic [2:0] nbeats;
  logic       accept;
  logic       active;
  logic       strobe;
  logic       beat_end;
  logic       last_beat;
  logic [1:0] beat_idx;
  logic       wr_q;

  assign nbeats = beats_of(width_q);

  nm_width_latch u_width (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_width (cfg_width),
    .width     (width_q)
  );

  nm_beat_seq #(.HOLD(HOLD)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .nbeats    (nbeats),
    .accept    (accept),
    .busy      (busy),
    .active    (active),
    .strobe    (strobe),
    .beat_end  (beat_end),
    .last_beat (last_beat),
    .ack       (ack),
    .beat_idx  (beat_idx)
  );

  nm_lane_path #(.AW(AW)) u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_write  (req_write),
    .big_endian (big_endian),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .width      (width_q),
    .beat_idx   (beat_idx),
    .beat_end   (beat_end),
    .ext_din    (ext_din),
    .wr_q       (wr_q),
    .ext_addr   (ext_addr),
    .ext_dout   (ext_dout),
    .rdata      (rdata)
  );

  assign ext_ce_n = !active;
  assign ext_oe_n = !(strobe && !wr_q);
  assign ext_we_n = !(strobe && wr_q);

endmodule

// File: rtl/nm_adapter_chk.sv
module nm_adapter_chk
  import nm_pkg::*;
#(
  parameter int AW   = 16,
  parameter int HOLD = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic [AW+1:0] ext_addr,
  input logic          ack,
  input logic          busy,
  input logic          accept,
  input logic          beat_end,
  input logic          last_beat,
  input port_w_e       width
);

  logic strb;
  logic strb_q;
  int   run_len;
  int   beat_cnt;

  assign strb = !oe_n || !we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strb_q   <= 1'b0;
      run_len  <= 0;
      beat_cnt <= 0;
    end else begin
      strb_q <= strb;
      if (strb) run_len <= strb_q ? run_len + 1 : 1;
      if (accept)              beat_cnt <= 0;
      else if (strb && !strb_q) beat_cnt <= beat_cnt + 1;
    end
  end

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  p_strobe_in_ce_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strb |-> !ce_n);

  p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strb && strb_q) |-> $stable(ext_addr));

  p_hold_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb && strb_q) |-> (run_len == HOLD));

  p_ack_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  p_ack_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_end && last_beat) |=> ack);

  p_beat_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (beat_cnt == int'(beats_of(width))));

  p_ack_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> busy);

  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(accept));

endmodule

bind nm_adapter nm_adapter_chk #(.AW(AW), .HOLD(HOLD)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (ext_ce_n),
  .oe_n      (ext_oe_n),
  .we_n      (ext_we_n),
  .ext_addr  (ext_addr),
  .ack       (ack),
  .busy      (busy),
  .accept    (accept),
  .beat_end  (beat_end),
  .last_beat (last_beat),
  .width     (width_q)
);

// File: tb/nm_adapter_tb.sv
module nm_adapter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 16;
  localparam int HOLD = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    cfg_width = 2'b00;
  logic          big_endian = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          busy, ack;
  logic [31:0]   rdata;
  logic          ext_ce_n, ext_oe_n, ext_we_n;
  logic [AW+1:0] ext_addr;
  logic [31:0]   ext_dout;
  logic [31:0]   ext_din;

  int checks = 0;
  int errors = 0;
  int bw = 8;                // bench's own notion of the port width

  logic [31:0] mem [0:255];
  logic [31:0] bmask;

  always #(CLK_PERIOD/2) clk = ~clk;

  nm_adapter #(.AW(AW), .HOLD(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .big_endian(big_endian),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .ack(ack), .rdata(rdata),
    .ext_ce_n(ext_ce_n), .ext_oe_n(ext_oe_n), .ext_we_n(ext_we_n),
    .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_din(ext_din)
  );

  assign bmask   = (bw == 8) ? 32'h0000_00FF : (bw == 16) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign ext_din = ext_oe_n ? 32'h0 : (mem[ext_addr[7:0]] & bmask);

  // external memory writes and bus monitor
  int          nb = 0, nwr = 0, badrun = 0, run = 0;
  logic        pstrb = 1'b0;
  logic [AW+1:0] baddr [0:7];

  always @(negedge clk) begin
    logic s;
    s = !ext_oe_n || !ext_we_n;
    if (!ext_we_n) mem[ext_addr[7:0]] = ext_dout & bmask;
    if (s && !pstrb) begin
      baddr[nb % 8] = ext_addr;
      nb = nb + 1;
      if (!ext_we_n) nwr = nwr + 1;
    end
    if (s) run = pstrb ? run + 1 : 1;
    if (!s && pstrb && run != HOLD) badrun = badrun + 1;
    pstrb = s;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input int w, input bit be, input int a);
    logic [31:0] r = '0;
    if (w == 8) begin
      for (int k = 0; k < 4; k++) begin
        int ln = be ? 3 - k : k;
        r[ln*8 +: 8] = mem[(a*4 + k) & 255][7:0];
      end
    end else if (w == 16) begin
      for (int h = 0; h < 2; h++) begin
        int ln = be ? 1 - h : h;
        r[ln*16 +: 16] = mem[(a*2 + h) & 255][15:0];
      end
    end else begin
      r = mem[a & 255];
    end
    return r;
  endfunction

  function automatic int beats(input int w);
    return (w == 8) ? 4 : (w == 16) ? 2 : 1;
  endfunction

  task automatic do_reset(input logic [1:0] code, input int w);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_width = code;
    bw = w;
    repeat (3) @(negedge clk);
    chk(ext_ce_n && ext_oe_n && ext_we_n, "R10 reset strobes", {29'd0, ext_ce_n, ext_oe_n, ext_we_n}, 32'h7);
    chk(!busy && !ack, "R10 reset busy/ack", {30'd0, busy, ack}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ext_ce_n && ext_oe_n && ext_we_n && !busy, "R10 idle after reset",
        {28'd0, busy, ext_ce_n, ext_oe_n, ext_we_n}, 32'h7);
  endtask

  // issue one request at a negedge, return data and the negedge index of ack
  task automatic txn(input bit wr, input bit be, input int a, input logic [31:0] wd,
                     output logic [31:0] rd, output int lat);
    req_valid = 1'b1; req_write = wr; big_endian = be;
    req_addr = AW'(a); req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    chk(busy, "R9 busy after accept", {31'd0, busy}, 32'h1);
    while (!ack && lat < 500) begin
      @(negedge clk);
      lat++;
    end
    rd = rdata;
    @(negedge clk);
    chk(!ack && !busy, "R8 ack one cycle", {30'd0, ack, busy}, 32'h0);
  endtask

  task automatic t_read(input bit be, input int a, input string tag);
    logic [31:0] rd, ex;
    int lat, nb0, br0, n;
    n = beats(bw);
    nb0 = nb; br0 = badrun;
    ex = exp_read(bw, be, a);
    txn(1'b0, be, a, 32'h0, rd, lat);
    chk(rd == ex, {tag, " R5 packed word"}, rd, ex);
    chk(nb - nb0 == n, {tag, " beat count"}, nb - nb0, n);
    chk(lat == n * (HOLD + 1), "R8 ack latency", lat, n * (HOLD + 1));
    chk(badrun == br0, "R7 strobe hold", badrun - br0, 0);
    for (int k = 0; k < n; k++) begin
      int ea = (bw == 8) ? a*4 + k : (bw == 16) ? a*2 + k : a;
      chk(baddr[(nb0 + k) % 8] == (AW+2)'(ea), {tag, " beat address"},
          32'(baddr[(nb0 + k) % 8]), ea);
    end
  endtask

  task automatic t_write(input bit be, input int a, input logic [31:0] wd, input string tag);
    logic [31:0] rd;
    int lat, w0, n;
    n = beats(bw);
    w0 = nwr;
    txn(1'b1, be, a, wd, rd, lat);
    chk(nwr - w0 == n, {tag, " R6 write beats"}, nwr - w0, n);
    chk(lat == n * (HOLD + 1), "R8 write latency", lat, n * (HOLD + 1));
    chk(exp_read(bw, be, a) == wd, {tag, " R6 stored lanes"}, exp_read(bw, be, a), wd);
    if (bw == 8) begin
      logic [7:0] b0 = be ? wd[31:24] : wd[7:0];
      chk(mem[(a*4) & 255][7:0] == b0, "R6 byte 0 lane", {24'd0, mem[(a*4) & 255][7:0]}, {24'd0, b0});
    end
  endtask

  // request held from inside a read through its ack cycle must be ignored
  task automatic t_overlap(input int a);
    int nb0, w0, c;
    nb0 = nb; w0 = nwr;
    req_valid = 1'b1; req_write = 1'b0; big_endian = 1'b0; req_addr = AW'(a);
    @(posedge clk);
    @(negedge clk);
    req_write = 1'b1; req_addr = AW'(a + 7); req_wdata = 32'hDEAD_BEEF;
    c = 1;
    while (!ack && c < 500) begin
      @(negedge clk);
      c++;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!busy, "R9 request in ack cycle ignored", {31'd0, busy}, 32'h0);
    repeat (4) @(negedge clk);
    chk(nwr == w0, "R9 no write while busy", nwr - w0, 0);
    chk(nb - nb0 == beats(bw), "R9 beats of first request only", nb - nb0, beats(bw));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hC35A_0000 ^ (i * 32'h0001_0307);

    do_reset(2'b00, 8);
    t_read(1'b0, 5, "R2 8-bit little");
    t_read(1'b1, 6, "R2 8-bit big");
    t_write(1'b1, 9, 32'h1122_3344, "R6 8-bit big");
    t_read(1'b1, 9, "R2 8-bit readback");
    cfg_width = 2'b10;            // R1: must not change width outside reset
    t_read(1'b0, 3, "R1 cfg ignored after reset");
    t_overlap(2);

    do_reset(2'b01, 16);
    t_read(1'b0, 11, "R3 16-bit little");
    t_read(1'b1, 12, "R3 16-bit big");
    t_write(1'b0, 20, 32'hA1B2_C3D4, "R6 16-bit little");
    chk(mem[40][15:0] == 16'hC3D4, "R5 low half at offset 0", {16'd0, mem[40][15:0]}, 32'h0000_C3D4);
    t_write(1'b1, 21, 32'h5566_7788, "R6 16-bit big");
    chk(mem[42][15:0] == 16'h5566, "R5 high half at offset 0", {16'd0, mem[42][15:0]}, 32'h0000_5566);

    do_reset(2'b10, 32);
    t_read(1'b0, 33, "R4 32-bit");
    t_read(1'b1, 34, "R4 32-bit big");
    t_write(1'b0, 35, 32'h0BAD_F00D, "R4 32-bit write");
    t_read(1'b0, 35, "R4 32-bit back-to-back");

    do_reset(2'b11, 32);
    t_read(1'b0, 40, "R1 code 11 is 32-bit");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule